// File: doc/BRIEF.md
# Dual-Channel Serial Converter Capture

This block runs one successive-approximation converter that holds two channels and reads them out over two serial data lanes at the same time. To begin a conversion it pulls an active-low convert strobe low. The strobe stays low for a programmable number of system clocks. The block then raises the strobe again, which lets the converter go back to sampling its inputs, and sends a burst of exactly sixteen serial clock pulses. The converter returns a copy of that clock. The data lanes are sampled on the rising edges of this returned copy, not on the clock the block generated. Any board or buffer delay between the two clocks therefore does not move the point where the data is sampled.

Both results are shifted in most significant bit first and are published together with a one-cycle valid pulse. A conversion starts either on an explicit request input or on an internal period counter, which gives a steady sample rate. A request that arrives while a conversion or readout is still running is dropped, and this sets a sticky overrun indication.

Top module: `dual_sar_capture`

## Requirements
- R1: While reset is high, and in the first cycle after it, cnv_n_o is 1, sclk_o is 0, valid_o is 0, overrun_o is 0 and both data outputs are 0.
- R2: A trigger (start_i high, or an internal rate tick) sampled on a clock edge while the block is idle drives cnv_n_o low from that edge. cnv_n_o then stays low for exactly conv_time_i cycles; a value of 0 counts as 1.
- R3: cnv_n_o is high in every cycle outside the conversion interval, and it is always high while sclk_o is high.
- R4: In the cycle right after cnv_n_o returns high, sclk_o begins exactly 16 pulses. Each pulse is high for one cycle and then low for one cycle, and no other pulses appear on sclk_o.
- R5: Data is sampled on the rising edges of echo_i, whatever their delay from sclk_o, and the first edge carries the most significant bit. Lane sdo_a_i builds data_a_o and lane sdo_b_i builds data_b_o.
- R6: valid_o is high for exactly one cycle, two cycles after the cycle in which echo_i is high for the 16th time. Both data outputs change only at that point and hold their value until the next valid pulse.
- R7: When auto_en_i is high, a trigger is produced every rate_i cycles, counted from the cycle in which auto_en_i was first sampled high. The period counter restarts whenever auto_en_i is low.
- R8: A trigger that arrives while a conversion or readout is in progress starts nothing and sets overrun_o, which then stays high until reset.
- R9: A trigger in the cycle after valid_o is accepted and does not set overrun_o.
- R10: Rising edges on echo_i while the block is idle do not change the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled each cycle |
| auto_en_i | input | 1 | Enables the internal period counter |
| rate_i | input | RATE_W | Trigger period in cycles for auto mode |
| conv_time_i | input | CT_W | Cycles the convert strobe stays low |
| cnv_n_o | output | 1 | Active-low convert strobe to the converter |
| sclk_o | output | 1 | Serial clock burst to the converter |
| echo_i | input | 1 | Returned copy of the serial clock |
| sdo_a_i | input | 1 | Serial data lane of the first channel |
| sdo_b_i | input | 1 | Serial data lane of the second channel |
| valid_o | output | 1 | One-cycle pulse when a result pair is ready |
| data_a_o | output | DATA_W | Result of the first channel |
| data_b_o | output | DATA_W | Result of the second channel |
| overrun_o | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
The hardest case to reach is a returned clock that lags far behind the local burst, with its last edges arriving after the local pulses have ended. The bench's converter model delays both the returned clock and the data lanes by a chosen number of cycles, so these late edges are produced at the ports. A second hard case is a request that lands exactly on the boundary after a result is published. The bench waits for the valid pulse at a negative edge and raises start_i in the following cycle. Stray returned-clock pulses are forced in while the block is idle, and the next result must still come out intact.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CONV  = 2'd1,
        SEQ_BURST = 2'd2,
        SEQ_DRAIN = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cnv_n;
        logic sclk;
        logic cap_clr;
        logic cap_en;
        logic busy;
    } seq_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dsc_rate.sv
module dsc_rate #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + {{RATE_W{1'b0}}, 1'b1};
    assign tick_o = auto_en_i && (cnt_nx >= {1'b0, rate_i});

    always_ff @(posedge clk) begin
        if (rst || !auto_en_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nx[RATE_W-1:0];
        end
    end
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CT_W   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_i,
    input  logic [CT_W-1:0] conv_time_i,
    input  logic            cap_done_i,
    output seq_ctl_t        ctl_o
);
    localparam int PC_W = cnt_bits(DATA_W);
    localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(DATA_W - 1);

    seq_state_e      state_q;
    logic [CT_W-1:0] cnt_q;
    logic [CT_W:0]   cnt_nx;
    logic            conv_done;
    logic            ph_q;
    logic [PC_W-1:0] pc_q;

    assign cnt_nx    = {1'b0, cnt_q} + {{CT_W{1'b0}}, 1'b1};
    assign conv_done = cnt_nx >= {1'b0, conv_time_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            ph_q    <= 1'b0;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (trig_i) begin
                        state_q <= SEQ_CONV;
                        cnt_q   <= '0;
                    end
                end
                SEQ_CONV: begin
                    if (conv_done) begin
                        state_q <= SEQ_BURST;
                        ph_q    <= 1'b1;
                        pc_q    <= '0;
                    end else begin
                        cnt_q <= cnt_nx[CT_W-1:0];
                    end
                end
                SEQ_BURST: begin
                    ph_q <= ~ph_q;
                    if (!ph_q) begin
                        if (pc_q == LAST_PULSE) begin
                            state_q <= SEQ_DRAIN;
                        end else begin
                            pc_q <= pc_q + 1'b1;
                        end
                    end
                end
                SEQ_DRAIN: begin
                    if (cap_done_i) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.cnv_n   = (state_q != SEQ_CONV);
        ctl_o.sclk    = (state_q == SEQ_BURST) && ph_q;
        ctl_o.cap_clr = (state_q == SEQ_CONV);
        ctl_o.cap_en  = (state_q == SEQ_BURST) || (state_q == SEQ_DRAIN);
        ctl_o.busy    = (state_q != SEQ_IDLE);
    end
endmodule

// File: rtl/dsc_capture.sv
module dsc_capture
    import dsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         en_i,
    input  logic                         echo_i,
    input  logic [LANES-1:0]             lane_i,
    output logic [LANES-1:0][DATA_W-1:0] word_o,
    output logic                         valid_o
);
    localparam int BC_W = cnt_bits(DATA_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    logic             echo_q;
    logic             echo_qq;
    logic [LANES-1:0] lane_q;
    logic [BC_W-1:0]  bc_q;
    logic             take;
    logic             last;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_q  <= 1'b0;
            echo_qq <= 1'b0;
            lane_q  <= '0;
        end else begin
            echo_q  <= echo_i;
            echo_qq <= echo_q;
            lane_q  <= lane_i;
        end
    end

    assign take = echo_q && !echo_qq && en_i;
    assign last = take && (bc_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            bc_q <= '0;
        end else if (take) begin
            bc_q <= last ? '0 : bc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= last;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DATA_W-1:0] sh_q;
        logic [DATA_W-1:0] word_q;
        logic [DATA_W-1:0] sh_nx;

        assign sh_nx = {sh_q[DATA_W-2:0], lane_q[l]};

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                word_q <= '0;
            end else begin
                if (take) begin
                    sh_q <= sh_nx;
                end
                if (last) begin
                    word_q <= sh_nx;
                end
            end
        end

        assign word_o[l] = word_q;
    end

    assign valid_o = valid_q;
endmodule

// File: rtl/dual_sar_capture.sv
module dual_sar_capture
    import dsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CT_W   = 8,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CT_W-1:0]   conv_time_i,
    output logic              cnv_n_o,
    output logic              sclk_o,
    input  logic              echo_i,
    input  logic              sdo_a_i,
    input  logic              sdo_b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_a_o,
    output logic [DATA_W-1:0] data_b_o,
    output logic              overrun_o
);
    localparam int LANES = 2;

    logic                         tick;
    logic                         trig;
    seq_ctl_t                     ctl;
    logic [LANES-1:0][DATA_W-1:0] words;
    logic                         cap_valid;
    logic                         overrun_q;

    dsc_rate #(.RATE_W(RATE_W)) u_rate (
        .clk       (clk),
        .rst       (rst),
        .auto_en_i (auto_en_i),
        .rate_i    (rate_i),
        .tick_o    (tick)
    );

    assign trig = start_i || tick;

    dsc_seq #(.DATA_W(DATA_W), .CT_W(CT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig),
        .conv_time_i (conv_time_i),
        .cap_done_i  (cap_valid),
        .ctl_o       (ctl)
    );

    dsc_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (ctl.cap_clr),
        .en_i    (ctl.cap_en),
        .echo_i  (echo_i),
        .lane_i  ({sdo_b_i, sdo_a_i}),
        .word_o  (words),
        .valid_o (cap_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_q <= 1'b0;
        end else if (trig && ctl.busy) begin
            overrun_q <= 1'b1;
        end
    end

    assign cnv_n_o   = ctl.cnv_n;
    assign sclk_o    = ctl.sclk;
    assign valid_o   = cap_valid;
    assign data_a_o  = words[0];
    assign data_b_o  = words[1];
    assign overrun_o = overrun_q;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst,
    input logic cnv_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic overrun_o
);
    logic       cnv_n_q;
    logic       sclk_q;
    logic [7:0] pulses_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_n_q  <= 1'b1;
            sclk_q   <= 1'b0;
            pulses_q <= '0;
        end else begin
            cnv_n_q <= cnv_n_o;
            sclk_q  <= sclk_o;
            if (cnv_n_q && !cnv_n_o) begin
                pulses_q <= '0;
            end else if (sclk_o && !sclk_q && pulses_q != 8'hFF) begin
                pulses_q <= pulses_q + 1'b1;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnv_n_o && !sclk_o && !valid_o && !overrun_o));

    assert_strobe_quiet_clock_R3: assert property (@(posedge clk) disable iff (rst)
        !cnv_n_o |-> !sclk_o);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |=> !sclk_o);

    assert_pulse_budget_R4: assert property (@(posedge clk) disable iff (rst)
        pulses_q <= 8'(DATA_W));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_valid_outside_convert_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cnv_n_o);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

bind dual_sar_capture dsc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnv_n_o   (cnv_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
);

// File: tb/dual_sar_capture_tb.sv
module dual_sar_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int CT_W = 8;
    localparam int RATE_W = 16;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic auto_en_i = 1'b0;
    logic [RATE_W-1:0] rate_i = '0;
    logic [CT_W-1:0] conv_time_i = '0;
    logic cnv_n_o, sclk_o, valid_o, overrun_o;
    logic echo_i = 1'b0, sdo_a_i = 1'b0, sdo_b_i = 1'b0;
    logic [DATA_W-1:0] data_a_o, data_b_o;

    int n_chk = 0;
    int n_err = 0;
    int dly = 0;
    bit cmp_en = 0;
    bit spur_on = 0;
    bit spur_tgl = 0;
    int fall_cnt = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_sar_capture #(.DATA_W(DATA_W), .CT_W(CT_W), .RATE_W(RATE_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_en_i(auto_en_i),
        .rate_i(rate_i), .conv_time_i(conv_time_i), .cnv_n_o(cnv_n_o),
        .sclk_o(sclk_o), .echo_i(echo_i), .sdo_a_i(sdo_a_i), .sdo_b_i(sdo_b_i),
        .valid_o(valid_o), .data_a_o(data_a_o), .data_b_o(data_b_o),
        .overrun_o(overrun_o)
    );

    function automatic logic [31:0] pattern(input int idx);
        logic [15:0] a;
        logic [15:0] b;
        if (idx == 0) return {16'hFFFF, 16'h0001};
        a = 16'hA5C3 + 16'(idx * 11037);
        b = {a[7:0], a[15:8]} ^ 16'h0F0F;
        return {a, b};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    bit m_act = 0;
    int m_t = 0, m_c = 1, m_d = 0, m_end = 0, m_n = 0, m_r = 0;
    bit m_ov = 0;
    logic [31:0] m_w = '0;

    always @(posedge clk) begin
        bit tick_m, trig_m;
        cyc++;
        if (rst) begin
            m_act = 0; m_t = 0; m_r = 0; m_ov = 0; m_n = 0;
        end else begin
            tick_m = auto_en_i && (m_r + 1 >= int'(rate_i));
            trig_m = start_i || tick_m;
            if (!auto_en_i || tick_m) m_r = 0; else m_r = m_r + 1;
            if (trig_m && m_act) m_ov = 1;
            if (m_act) begin
                m_t = m_t + 1;
                if (m_t > m_end) m_act = 0;
            end else if (trig_m) begin
                m_act = 1; m_t = 0;
                m_c = (conv_time_i == 0) ? 1 : int'(conv_time_i);
                m_d = dly;
                m_end = m_c + 32 + m_d;
                m_w = pattern(m_n);
                m_n = m_n + 1;
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        bit e_cnv, e_sclk, e_val;
        if (cmp_en && !rst) begin
            e_cnv  = !(m_act && m_t < m_c);
            e_sclk = m_act && m_t >= m_c && m_t < m_c + 32 && ((m_t - m_c) % 2 == 0);
            e_val  = m_act && m_t == m_end;
            check(cnv_n_o == e_cnv, e_cnv ? "R3" : "R2", "cnv_n_o", 32'(cnv_n_o), 32'(e_cnv));
            check(sclk_o == e_sclk, "R4", "sclk_o", 32'(sclk_o), 32'(e_sclk));
            check(valid_o == e_val, "R6", "valid_o", 32'(valid_o), 32'(e_val));
            if (e_val) begin
                check(data_a_o == m_w[31:16], "R5", "data_a_o", 32'(data_a_o), 32'(m_w[31:16]));
                check(data_b_o == m_w[15:0], "R5", "data_b_o", 32'(data_b_o), 32'(m_w[15:0]));
            end
            check(overrun_o == m_ov, "R8", "overrun_o", 32'(overrun_o), 32'(m_ov));
        end
    end

    // Converter model: shifts bits out on the local clock, echoes it with a delay
    bit prev_cnv = 1, prev_sclk = 0;
    int k = 0, c_n = 0;
    logic [31:0] c_w = '0;
    logic [7:0] h_e = '0, h_a = '0, h_b = '0;

    always @(negedge clk) begin
        logic ra, rb;
        if (prev_cnv && !cnv_n_o) begin
            c_w = pattern(c_n); c_n++; k = 0; fall_cnt++;
        end else if (prev_sclk && !sclk_o) begin
            k++;
        end
        ra = (k < 16) ? c_w[31 - k] : 1'b0;
        rb = (k < 16) ? c_w[15 - k] : 1'b0;
        h_e = {h_e[6:0], sclk_o};
        h_a = {h_a[6:0], ra};
        h_b = {h_b[6:0], rb};
        spur_tgl = ~spur_tgl;
        echo_i  = spur_on ? spur_tgl : h_e[dly];
        sdo_a_i = h_a[dly];
        sdo_b_i = h_b[dly];
        prev_cnv = cnv_n_o;
        prev_sclk = sclk_o;
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    initial begin
        int f0;
        idle(4);
        rst = 1'b0;
        // R1: state right after reset release
        check(cnv_n_o == 1'b1, "R1", "cnv_n_o", 32'(cnv_n_o), 1);
        check(sclk_o == 1'b0, "R1", "sclk_o", 32'(sclk_o), 0);
        check(valid_o == 1'b0, "R1", "valid_o", 32'(valid_o), 0);
        check(overrun_o == 1'b0, "R1", "overrun_o", 32'(overrun_o), 0);
        check(data_a_o == '0 && data_b_o == '0, "R1", "data", {data_a_o, data_b_o}, 0);
        cmp_en = 1;

        // R2 R4 R5: nominal conversion, no echo lag
        conv_time_i = 8'd4; dly = 0;
        pulse_start(); idle(60);

        // R2 R5 R6: zero conversion time treated as one, lagging echo
        conv_time_i = 8'd0; dly = 3;
        pulse_start(); idle(60);

        // R10: stray echo pulses while idle
        spur_on = 1; idle(12); spur_on = 0; idle(5);
        conv_time_i = 8'd2; dly = 2;
        pulse_start(); idle(60);
        check(data_a_o == pattern(2)[31:16], "R10", "data_a_o", 32'(data_a_o), 32'(pattern(2)[31:16]));
        check(data_b_o == pattern(2)[15:0], "R10", "data_b_o", 32'(data_b_o), 32'(pattern(2)[15:0]));

        // R9: request in the cycle after valid
        conv_time_i = 8'd3; dly = 1;
        pulse_start();
        do @(negedge clk); while (!valid_o);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(cnv_n_o == 1'b0, "R9", "cnv_n_o", 32'(cnv_n_o), 0);
        check(overrun_o == 1'b0, "R9", "overrun_o", 32'(overrun_o), 0);
        idle(60);

        // R7: automatic rate
        conv_time_i = 8'd4; dly = 1; rate_i = 16'd60;
        f0 = fall_cnt;
        auto_en_i = 1'b1; idle(200); auto_en_i = 1'b0; idle(60);
        check(fall_cnt - f0 == 3, "R7", "auto conversions", 32'(fall_cnt - f0), 3);

        // R8: request while busy
        check(overrun_o == 1'b0, "R8", "overrun_o before", 32'(overrun_o), 0);
        conv_time_i = 8'd8; dly = 0;
        f0 = fall_cnt;
        pulse_start(); idle(3); pulse_start();
        check(overrun_o == 1'b1, "R8", "overrun_o set", 32'(overrun_o), 1);
        idle(60);
        check(fall_cnt - f0 == 1, "R8", "conversions", 32'(fall_cnt - f0), 1);
        pulse_start(); idle(60);
        check(overrun_o == 1'b1, "R8", "overrun_o sticky", 32'(overrun_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule